// File: doc/BRIEF.md
# Eight-Level Priority Interrupt Controller

This block gathers interrupt requests from eight device lines and presents one request line to a processor. A rising edge on any line is remembered in a request register. Lines can be blocked one by one through a mask register. The controller forwards the most urgent unmasked request, but only when that request outranks every level the processor is already servicing. Line 0 is the most urgent and line 7 the least.

The processor answers with two acknowledge pulses. The request line drops after the first pulse. After the second pulse the controller returns an 8-bit vector one cycle later, qualified by a valid strobe. The vector holds a programmable 5-bit base in its upper bits and the line number in its low three bits. On that same pulse the winning line moves from the request register into the in-service register. It stays there until software issues an end-of-interrupt command. If nothing qualifies when the second pulse arrives, the controller returns the vector of line 7 and marks nothing in service.

Software reaches the block through a one-bit address. Odd-address writes and reads go to the mask register. Even-address writes are commands, and even-address reads return either the request register or the in-service register. A separate configuration strobe loads the vector base.

Top module: `intc_core`

## Requirements
- R1: After reset the request, in-service and mask registers are zero, the vector base is zero, `intReq` and `vecValid` are low, and even-address reads return the request register.
- R2: A rising edge on `irqIn[i]` sets request bit i at the next clock edge. The bit stays set after the line falls, until line i is acknowledged.
- R3: Mask bit i set to 1 keeps request i from being forwarded, although request bit i still latches. A write with `addr`=1 loads the mask from `wrData`, and a read with `addr`=1 returns it.
- R4: `intReq` is high whenever an unmasked request is pending and the in-service register is empty.
- R5: `intReq` is low in the cycle after the first acknowledge pulse, until the second pulse has been taken.
- R6: On the second acknowledge pulse, `vecValid` is high for exactly one cycle in the following cycle. In that cycle `vecOut` = {base[4:0], line[2:0]}. The winning line's in-service bit is set and its request bit is cleared.
- R7: Among several unmasked pending requests, the lowest line number wins.
- R8: While line s is in service, only an unmasked request on a line numbered below s raises `intReq`. Requests on line s or above are held back.
- R9: An even-address write with `wrData[7:5]`=001 clears only the lowest-numbered set in-service bit.
- R10: An even-address write with `wrData[7:5]`=010 selects the register for even-address reads: `wrData[0]`=0 selects requests, 1 selects in-service.
- R11: A `cfgWr` strobe loads the vector base from `wrData[7:3]`.
- R12: If no request qualifies at the second pulse, `vecOut` = {base, 3'b111}, no in-service bit is set, and the request register is unchanged.
- R13: A new edge on the line being acknowledged in the same cycle leaves its request bit set. An end-of-interrupt in the same cycle as a grant applies both changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| irqIn | input | 8 | Device request lines, bit 0 most urgent |
| wrEn | input | 1 | Register write strobe |
| addr | input | 1 | 0 = command/status, 1 = mask |
| wrData | input | 8 | Write data |
| cfgWr | input | 1 | Vector base load strobe, base from wrData[7:3] |
| rdData | output | 8 | Read data for the addressed register |
| ackIn | input | 1 | Acknowledge pulse from the processor, one cycle per pulse |
| intReq | output | 1 | Interrupt request to the processor |
| vecOut | output | 8 | Vector, valid while vecValid is high |
| vecValid | output | 1 | One-cycle vector qualifier |

## Verification
Two collisions can happen in the same cycle. The first is a grant on the second acknowledge pulse together with a fresh edge on the same line. The bench drives both at one clock edge. It then expects the granted vector and a request bit that is still set on read-back. The second is a grant together with an end-of-interrupt write. The bench drives the second pulse and the command in the same cycle. It then expects the in-service register to hold only the newly granted line, with the earlier line cleared.

// File: rtl/intc_pkg.sv
package intc_pkg;
  localparam int CMD_W = 3;
  localparam logic [CMD_W-1:0] CMD_EOI = 3'b001;
  localparam logic [CMD_W-1:0] CMD_SEL = 3'b010;

  typedef struct packed {
    logic grant;     // second acknowledge pulse taken
    logic loadMask;  // odd-address write
    logic loadBase;  // vector base load
    logic eoi;       // non-specific end of interrupt
    logic selWr;     // read-select command
  } ctrlStrobe_t;
endpackage

// File: rtl/intc_regs.sv
module intc_regs
  import intc_pkg::*;
#(
  parameter int NUM_IRQ = 8,
  parameter int DATA_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NUM_IRQ-1:0] irqIn,
  input  logic              addr,
  input  logic [DATA_W-1:0] wrData,
  input  ctrlStrobe_t       strobe,
  output logic [DATA_W-1:0] rdData,
  output logic [DATA_W-1:0] vecOut,
  output logic              vecValid,
  output logic              canForward
);
  localparam int IDX_W  = $clog2(NUM_IRQ);
  localparam int BASE_W = DATA_W - IDX_W;
  localparam logic [IDX_W-1:0] SPUR_IDX = IDX_W'(NUM_IRQ - 1);

  logic [NUM_IRQ-1:0] irqPrev, rise, reqLatch, inService, maskReg;
  logic [NUM_IRQ-1:0] pend, reqClr, svcClr, svcSet;
  logic [BASE_W-1:0]  vecBase;
  logic               selSvc;
  logic [IDX_W-1:0]   pendIdx, svcIdx;
  logic               pendAny, svcAny;

  assign rise = irqIn & ~irqPrev;
  assign pend = reqLatch & ~maskReg;

  // Priority encoders: lowest index wins, loop runs downward so it is last
  always_comb begin
    pendIdx = '0;
    pendAny = 1'b0;
    svcIdx  = '0;
    svcAny  = 1'b0;
    for (int i = NUM_IRQ - 1; i >= 0; i--) begin
      if (pend[i]) begin
        pendIdx = IDX_W'(i);
        pendAny = 1'b1;
      end
      if (inService[i]) begin
        svcIdx = IDX_W'(i);
        svcAny = 1'b1;
      end
    end
  end

  assign canForward = pendAny && (!svcAny || (pendIdx < svcIdx));

  always_comb begin
    reqClr = '0;
    svcSet = '0;
    svcClr = '0;
    if (strobe.grant && canForward) begin
      reqClr[pendIdx] = 1'b1;
      svcSet[pendIdx] = 1'b1;
    end
    if (strobe.eoi && svcAny) svcClr[svcIdx] = 1'b1;
  end

  // One request flop per line; a new edge wins over a clear in the same cycle
  for (genvar g = 0; g < NUM_IRQ; g++) begin : g_req
    always_ff @(posedge clk) begin
      if (!rstN) begin
        irqPrev[g]  <= 1'b0;
        reqLatch[g] <= 1'b0;
      end else begin
        irqPrev[g]  <= irqIn[g];
        reqLatch[g] <= (reqLatch[g] & ~reqClr[g]) | rise[g];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      inService <= '0;
      maskReg   <= '0;
      vecBase   <= '0;
      selSvc    <= 1'b0;
      vecOut    <= '0;
      vecValid  <= 1'b0;
    end else begin
      inService <= (inService & ~svcClr) | svcSet;
      if (strobe.loadMask) maskReg <= wrData[NUM_IRQ-1:0];
      if (strobe.loadBase) vecBase <= wrData[DATA_W-1 -: BASE_W];
      if (strobe.selWr)    selSvc  <= wrData[0];
      vecValid <= strobe.grant;
      if (strobe.grant)
        vecOut <= {vecBase, (canForward ? pendIdx : SPUR_IDX)};
    end
  end

  always_comb begin
    rdData = '0;
    if (addr)        rdData[NUM_IRQ-1:0] = maskReg;
    else if (selSvc) rdData[NUM_IRQ-1:0] = inService;
    else             rdData[NUM_IRQ-1:0] = reqLatch;
  end

  // R2: an edge is recorded at the next clock edge
  p_edge_latched_r2: assert property (@(posedge clk) disable iff (!rstN)
    (rise != '0) |=> ((reqLatch & $past(rise)) == $past(rise)));
  // R3: forwarding implies some unmasked pending request
  p_fwd_unmasked_r3: assert property (@(posedge clk) disable iff (!rstN)
    canForward |-> ((reqLatch & ~maskReg) != '0));
  // R6: granted line becomes in service
  p_grant_sets_svc_r6: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.grant && canForward) |=> inService[$past(pendIdx)]);
  // R6: vector strobe lasts one cycle
  p_vec_pulse_r6: assert property (@(posedge clk) disable iff (!rstN)
    vecValid |=> !vecValid);
  // R12: spurious grant leaves in-service alone
  p_spurious_keeps_svc_r12: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.grant && !canForward && !strobe.eoi) |=> (inService == $past(inService)));
  // R9: end of interrupt removes exactly one level
  p_eoi_single_r9: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.eoi && (inService != '0) && !strobe.grant)
      |=> ($countones(inService) == $countones($past(inService)) - 1));
endmodule

// File: rtl/intc_ctrl.sv
module intc_ctrl
  import intc_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ackIn,
  input  logic              wrEn,
  input  logic              addr,
  input  logic              cfgWr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              canForward,
  output ctrlStrobe_t       strobe,
  output logic              intReq
);
  typedef enum logic {ACK_IDLE, ACK_WAIT2} ackState_t;

  ackState_t ackState;
  logic [CMD_W-1:0] cmdField;

  assign cmdField = wrData[DATA_W-1 -: CMD_W];

  always_ff @(posedge clk) begin
    if (!rstN) ackState <= ACK_IDLE;
    else if (ackIn)
      ackState <= (ackState == ACK_IDLE) ? ACK_WAIT2 : ACK_IDLE;
  end

  always_comb begin
    strobe.grant    = ackIn && (ackState == ACK_WAIT2);
    strobe.loadMask = wrEn && addr;
    strobe.loadBase = cfgWr;
    strobe.eoi      = wrEn && !addr && (cmdField == CMD_EOI);
    strobe.selWr    = wrEn && !addr && (cmdField == CMD_SEL);
  end

  assign intReq = (ackState == ACK_IDLE) && canForward;

  // R5: the request line is down once the first pulse is taken
  p_int_drops_r5: assert property (@(posedge clk) disable iff (!rstN)
    (ackIn && (ackState == ACK_IDLE)) |=> !intReq);
endmodule

// File: rtl/intc_core.sv
module intc_core
  import intc_pkg::*;
#(
  parameter int NUM_IRQ = 8,
  parameter int DATA_W  = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_IRQ-1:0] irqIn,
  input  logic               wrEn,
  input  logic               addr,
  input  logic [DATA_W-1:0]  wrData,
  input  logic               cfgWr,
  output logic [DATA_W-1:0]  rdData,
  input  logic               ackIn,
  output logic               intReq,
  output logic [DATA_W-1:0]  vecOut,
  output logic               vecValid
);
  ctrlStrobe_t strobe;
  logic        canForward;

  intc_ctrl #(.DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .ackIn(ackIn), .wrEn(wrEn), .addr(addr),
    .cfgWr(cfgWr), .wrData(wrData), .canForward(canForward),
    .strobe(strobe), .intReq(intReq)
  );

  intc_regs #(.NUM_IRQ(NUM_IRQ), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rstN(rstN), .irqIn(irqIn), .addr(addr), .wrData(wrData),
    .strobe(strobe), .rdData(rdData), .vecOut(vecOut), .vecValid(vecValid),
    .canForward(canForward)
  );
endmodule

// File: tb/intc_core_test.sv
`timescale 1ns/1ps
module intc_core_test;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] irqIn = '0;
  logic       wrEn = 1'b0;
  logic       addr = 1'b0;
  logic [7:0] wrData = '0;
  logic       cfgWr = 1'b0;
  logic [7:0] rdData;
  logic       ackIn = 1'b0;
  logic       intReq;
  logic [7:0] vecOut;
  logic       vecValid;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  intc_core uut (
    .clk(clk), .rstN(rstN), .irqIn(irqIn), .wrEn(wrEn), .addr(addr),
    .wrData(wrData), .cfgWr(cfgWr), .rdData(rdData), .ackIn(ackIn),
    .intReq(intReq), .vecOut(vecOut), .vecValid(vecValid)
  );

  // Row: {base[4:0], mask[7:0], lines[7:0], expInt, expVec[7:0]}
  localparam logic [29:0] TBL [6] = '{
    {5'h04, 8'h00, 8'h80, 1'b1, 8'h27},   // R4 single low-urgency line
    {5'h01, 8'h00, 8'h28, 1'b1, 8'h0B},   // R7 line 3 beats line 5
    {5'h1F, 8'h08, 8'h28, 1'b1, 8'hFD},   // R3 line 3 masked, line 5 wins
    {5'h02, 8'hFF, 8'h11, 1'b0, 8'h17},   // R12 all masked -> spurious
    {5'h00, 8'h01, 8'h01, 1'b0, 8'h07},   // R12 only line masked
    {5'h10, 8'h00, 8'hFF, 1'b1, 8'h80}    // R7 all lines, line 0 wins
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic doReset();
    rstN = 1'b0; irqIn = '0; wrEn = 1'b0; cfgWr = 1'b0; ackIn = 1'b0; addr = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  task automatic regWrite(input logic a, input logic [7:0] d);
    wrEn = 1'b1; addr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0; addr = 1'b0;
  endtask

  task automatic setBase(input logic [4:0] b);
    cfgWr = 1'b1; wrData = {b, 3'b000};
    @(negedge clk);
    cfgWr = 1'b0;
  endtask

  task automatic regRead(input logic a, output logic [7:0] v);
    addr = a;
    #1 v = rdData;
    addr = 1'b0;
  endtask

  task automatic pulseLines(input logic [7:0] p);
    irqIn = p;
    @(negedge clk);
    irqIn = '0;
  endtask

  task automatic ackFirst();
    ackIn = 1'b1;
    @(negedge clk);
    ackIn = 1'b0;
    chk("R5 intReq after first pulse", {7'd0, intReq}, 8'h00);
  endtask

  task automatic ackSecond(input logic [7:0] expVec, input string req);
    ackIn = 1'b1;
    @(negedge clk);
    ackIn = 1'b0;
    chk("R6 vecValid", {7'd0, vecValid}, 8'h01);
    chk(req, vecOut, expVec);
    @(negedge clk);
    chk("R6 vecValid single cycle", {7'd0, vecValid}, 8'h00);
  endtask

  initial begin
    #1000000;
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] v;

    // R1 reset state
    doReset();
    chk("R1 intReq", {7'd0, intReq}, 8'h00);
    chk("R1 vecValid", {7'd0, vecValid}, 8'h00);
    regRead(1'b0, v); chk("R1 request reg", v, 8'h00);
    regRead(1'b1, v); chk("R1 mask reg", v, 8'h00);
    regWrite(1'b0, 8'h41);
    regRead(1'b0, v); chk("R1 in-service reg", v, 8'h00);
    ackFirst();
    ackSecond(8'h07, "R1 base zero spurious vector");

    // Table walk
    for (int k = 0; k < 6; k++) begin
      logic [29:0] row;
      row = TBL[k];
      doReset();
      setBase(row[29:25]);                       // R11
      regWrite(1'b1, row[24:17]);
      pulseLines(row[16:9]);
      chk("R4 R3 intReq per row", {7'd0, intReq}, {7'd0, row[8]});
      ackFirst();
      ackSecond(row[7:0], "R11 R7 R12 row vector");
    end

    // R2 / R3 latching under mask, mask read-back
    doReset();
    regWrite(1'b1, 8'h04);
    pulseLines(8'h04);
    @(negedge clk);
    regRead(1'b0, v); chk("R2 request held after line fell", v, 8'h04);
    chk("R3 masked request not forwarded", {7'd0, intReq}, 8'h00);
    regRead(1'b1, v); chk("R3 mask read-back", v, 8'h04);
    regWrite(1'b1, 8'h00);
    chk("R4 unmask forwards", {7'd0, intReq}, 8'h01);

    // R6 / R8 / R9 / R10 nesting
    doReset();
    pulseLines(8'h20);
    ackFirst();
    ackSecond(8'h05, "R6 line 5 vector");
    regRead(1'b0, v); chk("R6 request cleared", v, 8'h00);
    regWrite(1'b0, 8'h41);
    regRead(1'b0, v); chk("R10 R6 in-service read", v, 8'h20);
    pulseLines(8'h20);
    chk("R8 equal level held", {7'd0, intReq}, 8'h00);
    pulseLines(8'h80);
    chk("R8 lower level held", {7'd0, intReq}, 8'h00);
    pulseLines(8'h02);
    chk("R8 higher level forwarded", {7'd0, intReq}, 8'h01);
    ackFirst();
    ackSecond(8'h01, "R8 nested vector");
    regRead(1'b0, v); chk("R6 two levels in service", v, 8'h22);
    regWrite(1'b0, 8'h20);
    regRead(1'b0, v); chk("R9 eoi clears most urgent", v, 8'h20);
    chk("R8 line 5 pending held", {7'd0, intReq}, 8'h00);
    regWrite(1'b0, 8'h40);
    regRead(1'b0, v); chk("R10 select requests", v, 8'hA0);
    regWrite(1'b0, 8'h20);
    chk("R9 second eoi releases", {7'd0, intReq}, 8'h01);

    // R12 request masked between pulses
    doReset();
    pulseLines(8'h08);
    chk("R4 line 3 forwarded", {7'd0, intReq}, 8'h01);
    ackFirst();
    regWrite(1'b1, 8'h08);
    ackSecond(8'h07, "R12 spurious vector");
    regRead(1'b0, v); chk("R12 request unchanged", v, 8'h08);
    regWrite(1'b0, 8'h41);
    regRead(1'b0, v); chk("R12 nothing in service", v, 8'h00);

    // R13 new edge on the granted line in the grant cycle
    doReset();
    pulseLines(8'h10);
    ackFirst();
    ackIn = 1'b1; irqIn = 8'h10;
    @(negedge clk);
    ackIn = 1'b0; irqIn = '0;
    chk("R13 edge+grant vector", vecOut, 8'h04);
    regRead(1'b0, v); chk("R13 request kept", v, 8'h10);
    chk("R8 same line held", {7'd0, intReq}, 8'h00);

    // R13 end of interrupt in the grant cycle
    doReset();
    pulseLines(8'h40);
    ackFirst();
    ackSecond(8'h06, "R6 line 6 vector");
    pulseLines(8'h01);
    chk("R8 line 0 over line 6", {7'd0, intReq}, 8'h01);
    ackFirst();
    ackIn = 1'b1; wrEn = 1'b1; addr = 1'b0; wrData = 8'h20;
    @(negedge clk);
    ackIn = 1'b0; wrEn = 1'b0;
    chk("R13 eoi+grant vecValid", {7'd0, vecValid}, 8'h01);
    chk("R13 eoi+grant vector", vecOut, 8'h00);
    regWrite(1'b0, 8'h41);
    regRead(1'b0, v); chk("R13 in-service after both", v, 8'h01);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule